// File: doc/BRIEF.md
# Voltage-Frequency Operating-Point Sequencer

This block moves a core between a small set of operating points, each pairing a PLL frequency selection with a 6-bit supply-voltage code. Two governors request targets: one driven by workload and one driven by temperature. The sequencer drives the voltage code and the frequency select one at a time. It waits a programmable settle time after every voltage step. After every frequency step it waits for the PLL to drop lock and then regain it.

The direction of the move sets the order of the two steps. When speeding up, the supply is raised first and the frequency second. When slowing down, the frequency drops first and the supply follows. Only one move is in progress at a time. A request that arrives during a move is stored in a single slot, and a newer request replaces an older one. The stored request starts as soon as the current move ends. When both governors request in the same cycle, the lower operating point is taken.

Top module: `vf_sequencer`

## Requirements
- R1: After reset, vidCode is BOOT_VID (default 32, i.e. 1.196 V, the grid code nearest 1.20 V), freqSel is 0 and busy is low.
- R2: Voltage code c means 1.708 V − c × 16 mV. Operating point i (0 = slowest) is given code VID_LOW − i × VID_STRIDE, which is 47, 36, 25 and 14 by default. After a move to point i ends, vidCode holds that code and freqSel equals i.
- R3: For a move to a higher point, vidCode changes first. freqSel changes exactly settleCycles + 1 cycles later. The move ends once pllLock has been seen low and then high again.
- R4: For a move to a lower point, freqSel changes first. vidCode changes only after pllLock has gone low and then high again. The move ends settleCycles + 1 cycles after the voltage step.
- R5: When loadValid and thermValid are both high in the same cycle, the lower of loadIdx and thermIdx is the target. When only one is high, that source's index is the target.
- R6: A request that arrives while busy is high does not disturb the move in progress. It is kept in one slot, and a later request replaces it. The kept request starts in the cycle after the current move ends.
- R7: A request for the operating point already in force changes neither vidCode nor freqSel, and busy stays low. This holds at boot as well, so vidCode remains BOOT_VID.
- R8: busy rises in the cycle after a request is accepted and falls after the final step. vidCode and freqSel change only in cycles where busy is high.
- R9: vidCode and freqSel never change in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadValid | input | 1 | Workload governor request strobe |
| loadIdx | input | IDX_W | Workload governor target point |
| thermValid | input | 1 | Thermal governor request strobe |
| thermIdx | input | IDX_W | Thermal governor target point |
| pllLock | input | 1 | PLL lock indication |
| settleCycles | input | SETTLE_W | Extra wait cycles after each voltage step |
| vidCode | output | 6 | Supply voltage code |
| freqSel | output | IDX_W | PLL frequency select (operating point index) |
| busy | output | 1 | A move is in progress |

## Verification
The assertions check four things on every cycle:
- both outputs move only while busy is high;
- the voltage and frequency steps never coincide;
- any new voltage code lies on the operating-point grid;
- the step direction matches the voltage relation: when the frequency rises, the supply is already at the target code, and when it falls, the supply is still above the target.

Only the bench scenarios can show the exact settle gap, the arbitration between the two governors, the overwrite of a deferred request, and the no-op behaviour of a same-point request. They do this with a sweep over every pair of start and target points at several settle values.

// File: rtl/vf_seq_pkg.sv
package vf_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UP_SETTLE,
    ST_UP_LOCK,
    ST_DN_LOCK,
    ST_DN_SETTLE
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic takePend;   // start request consumed, clear deferred slot
    logic startUp;    // latch target, drive new voltage first
    logic startDown;  // latch target, drive new frequency first
    logic stepFreq;   // second step of an upward move
    logic stepVid;    // second step of a downward move
    logic commit;     // move finished, target becomes current
  } seqStrobe_t;

endpackage

// File: rtl/vf_seq_ctrl.sv
module vf_seq_ctrl
  import vf_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic       goUp,
  input  logic       goSame,
  input  logic       settleDone,
  input  logic       lockFresh,
  output seqStrobe_t strb,
  output logic       busy
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (startValid) begin
          strb.takePend = 1'b1;
          if (!goSame) begin
            if (goUp) begin
              strb.startUp = 1'b1;
              nextState    = ST_UP_SETTLE;
            end else begin
              strb.startDown = 1'b1;
              nextState      = ST_DN_LOCK;
            end
          end
        end
      end
      ST_UP_SETTLE: if (settleDone) begin
        strb.stepFreq = 1'b1;
        nextState     = ST_UP_LOCK;
      end
      ST_UP_LOCK: if (lockFresh) begin
        strb.commit = 1'b1;
        nextState   = ST_IDLE;
      end
      ST_DN_LOCK: if (lockFresh) begin
        strb.stepVid = 1'b1;
        nextState    = ST_DN_SETTLE;
      end
      ST_DN_SETTLE: if (settleDone) begin
        strb.commit = 1'b1;
        nextState   = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/vf_seq_datapath.sv
module vf_seq_datapath
  import vf_seq_pkg::*;
#(
  parameter int NUM_PTS    = 4,
  parameter int IDX_W      = 2,
  parameter int SETTLE_W   = 8,
  parameter int VID_LOW    = 47,
  parameter int VID_STRIDE = 11,
  parameter int BOOT_VID   = 32,
  parameter int BOOT_IDX   = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                loadValid,
  input  logic [IDX_W-1:0]    loadIdx,
  input  logic                thermValid,
  input  logic [IDX_W-1:0]    thermIdx,
  input  logic                pllLock,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                busy,
  input  seqStrobe_t          strb,
  output logic                startValid,
  output logic                goUp,
  output logic                goSame,
  output logic                settleDone,
  output logic                lockFresh,
  output logic [5:0]          vidCode,
  output logic [IDX_W-1:0]    freqSel
);

  // Voltage code per operating point, slowest point has the lowest supply
  logic [5:0] vidTable [NUM_PTS];
  for (genvar g = 0; g < NUM_PTS; g++) begin : g_vid
    assign vidTable[g] = 6'(VID_LOW - g * VID_STRIDE);
  end

  logic                reqValid;
  logic [IDX_W-1:0]    reqIdx, startIdx, curIdx, tgtIdx, pendIdx;
  logic                pendValid;
  logic [SETTLE_W-1:0] settleCnt;
  logic                seenUnlock;

  // Lower target wins when both governors ask at once
  always_comb begin
    reqValid = loadValid | thermValid;
    if (loadValid && thermValid) reqIdx = (loadIdx < thermIdx) ? loadIdx : thermIdx;
    else if (thermValid)         reqIdx = thermIdx;
    else                         reqIdx = loadIdx;
  end

  assign startValid = reqValid | pendValid;
  assign startIdx   = reqValid ? reqIdx : pendIdx;
  assign goUp       = startIdx > curIdx;
  assign goSame     = startIdx == curIdx;
  assign settleDone = (settleCnt == '0);
  assign lockFresh  = seenUnlock & pllLock;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vidCode    <= 6'(BOOT_VID);
      freqSel    <= IDX_W'(BOOT_IDX);
      curIdx     <= IDX_W'(BOOT_IDX);
      tgtIdx     <= IDX_W'(BOOT_IDX);
      pendIdx    <= '0;
      pendValid  <= 1'b0;
      settleCnt  <= '0;
      seenUnlock <= 1'b0;
    end else begin
      if (strb.startUp || strb.startDown) tgtIdx <= startIdx;
      if (strb.startUp)   vidCode <= vidTable[startIdx];
      if (strb.stepVid)   vidCode <= vidTable[tgtIdx];
      if (strb.startDown) freqSel <= startIdx;
      if (strb.stepFreq)  freqSel <= tgtIdx;
      if (strb.commit)    curIdx  <= tgtIdx;

      // single deferred slot, newest request overwrites
      if (busy && reqValid) begin
        pendValid <= 1'b1;
        pendIdx   <= reqIdx;
      end else if (strb.takePend) begin
        pendValid <= 1'b0;
      end

      if (strb.startUp || strb.stepVid) settleCnt <= settleCycles;
      else if (settleCnt != '0)          settleCnt <= settleCnt - 1'b1;

      // lock counts only once it has been seen low after a frequency step
      if (strb.startDown || strb.stepFreq) seenUnlock <= 1'b0;
      else if (!pllLock)                   seenUnlock <= 1'b1;
    end
  end

endmodule

// File: rtl/vf_sequencer.sv
module vf_sequencer
  import vf_seq_pkg::*;
#(
  parameter int NUM_PTS    = 4,
  parameter int SETTLE_W   = 8,
  parameter int VID_LOW    = 47,
  parameter int VID_STRIDE = 11,
  parameter int BOOT_VID   = 32,
  parameter int BOOT_IDX   = 0,
  localparam int IDX_W     = (NUM_PTS > 1) ? $clog2(NUM_PTS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                loadValid,
  input  logic [IDX_W-1:0]    loadIdx,
  input  logic                thermValid,
  input  logic [IDX_W-1:0]    thermIdx,
  input  logic                pllLock,
  input  logic [SETTLE_W-1:0] settleCycles,
  output logic [5:0]          vidCode,
  output logic [IDX_W-1:0]    freqSel,
  output logic                busy
);

  seqStrobe_t strb;
  logic startValid, goUp, goSame, settleDone, lockFresh;

  vf_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .goUp       (goUp),
    .goSame     (goSame),
    .settleDone (settleDone),
    .lockFresh  (lockFresh),
    .strb       (strb),
    .busy       (busy)
  );

  vf_seq_datapath #(
    .NUM_PTS    (NUM_PTS),
    .IDX_W      (IDX_W),
    .SETTLE_W   (SETTLE_W),
    .VID_LOW    (VID_LOW),
    .VID_STRIDE (VID_STRIDE),
    .BOOT_VID   (BOOT_VID),
    .BOOT_IDX   (BOOT_IDX)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .loadValid    (loadValid),
    .loadIdx      (loadIdx),
    .thermValid   (thermValid),
    .thermIdx     (thermIdx),
    .pllLock      (pllLock),
    .settleCycles (settleCycles),
    .busy         (busy),
    .strb         (strb),
    .startValid   (startValid),
    .goUp         (goUp),
    .goSame       (goSame),
    .settleDone   (settleDone),
    .lockFresh    (lockFresh),
    .vidCode      (vidCode),
    .freqSel      (freqSel)
  );

endmodule

// File: rtl/vf_sequencer_chk.sv
module vf_sequencer_chk #(
  parameter int NUM_PTS    = 4,
  parameter int SETTLE_W   = 8,
  parameter int VID_LOW    = 47,
  parameter int VID_STRIDE = 11,
  parameter int IDX_W      = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                pllLock,
  input logic [SETTLE_W-1:0] settleCycles,
  input logic [5:0]          vidCode,
  input logic [IDX_W-1:0]    freqSel,
  input logic                busy
);

  function automatic logic [5:0] vidOf(input logic [IDX_W-1:0] i);
    return 6'(VID_LOW - int'(i) * VID_STRIDE);
  endfunction

  function automatic logic onGrid(input logic [5:0] c);
    logic hit = 1'b0;
    for (int i = 0; i < NUM_PTS; i++)
      if (c == 6'(VID_LOW - i * VID_STRIDE)) hit = 1'b1;
    return hit;
  endfunction

  AST_VID_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(vidCode) |-> busy);                                   // R8
  AST_FREQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(freqSel) |-> busy);                                   // R8
  AST_NO_DUAL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(vidCode) |-> $stable(freqSel));                       // R9
  AST_VID_ON_GRID: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(vidCode) |-> onGrid(vidCode));                        // R2
  AST_UP_VOLT_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (freqSel > $past(freqSel)) |-> (vidCode == vidOf(freqSel)));   // R3
  AST_DOWN_VOLT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (freqSel < $past(freqSel)) |-> (vidCode < vidOf(freqSel)));    // R4

endmodule

bind vf_sequencer vf_sequencer_chk #(
  .NUM_PTS    (NUM_PTS),
  .SETTLE_W   (SETTLE_W),
  .VID_LOW    (VID_LOW),
  .VID_STRIDE (VID_STRIDE),
  .IDX_W      (IDX_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .pllLock      (pllLock),
  .settleCycles (settleCycles),
  .vidCode      (vidCode),
  .freqSel      (freqSel),
  .busy         (busy)
);

// File: tb/vf_sequencer_tb.sv
module vf_sequencer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NPTS       = 4;
  localparam int IW         = 2;
  localparam int SW         = 8;
  localparam int LOCK_DLY   = 3;
  localparam int WDOG       = 100000;

  logic          clk = 1'b0, rstN = 1'b0;
  logic          loadValid = 1'b0, thermValid = 1'b0, pllLock = 1'b1;
  logic [IW-1:0] loadIdx = '0, thermIdx = '0;
  logic [SW-1:0] settleCycles = '0;
  logic [5:0]    vidCode;
  logic [IW-1:0] freqSel;
  logic          busy;

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  // observations of the latest move
  logic [5:0]    pv;
  logic [IW-1:0] pf;
  int  vidChg, freqChg;
  bit  sawBusy, dual, idleChg;
  logic [NPTS-1:0] freqMask;

  always #(CLK_PERIOD/2) clk = ~clk;

  vf_sequencer u_dut (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadIdx(loadIdx),
    .thermValid(thermValid), .thermIdx(thermIdx), .pllLock(pllLock),
    .settleCycles(settleCycles), .vidCode(vidCode), .freqSel(freqSel), .busy(busy)
  );

  // 1.708 V - 16 mV per code; points at 47, 36, 25, 14
  function automatic int expVid(int i);
    return 47 - 11 * i;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // PLL model: drops lock when the select moves, relocks LOCK_DLY samples later
  initial begin
    logic [IW-1:0] lastSel = '0;
    int lockCnt = 0;
    forever begin
      @(negedge clk);
      if (freqSel != lastSel) begin
        pllLock = 1'b0;
        lockCnt = LOCK_DLY;
        lastSel = freqSel;
      end else if (lockCnt > 0) begin
        lockCnt--;
        if (lockCnt == 0) pllLock = 1'b1;
      end
    end
  end

  task automatic issue(bit lv, int li, bit tv, int ti);
    @(negedge clk);
    pv = vidCode; pf = freqSel;
    loadValid = lv; loadIdx = IW'(li); thermValid = tv; thermIdx = IW'(ti);
    @(negedge clk);
    loadValid = 1'b0; thermValid = 1'b0;
  endtask

  task automatic track();
    int cyc = 0;
    int idleRun = 0;
    bit vc, fc;
    vidChg = -1; freqChg = -1; sawBusy = 0; dual = 0; idleChg = 0; freqMask = '0;
    while (idleRun < 2) begin
      vc = (vidCode != pv);
      fc = (freqSel != pf);
      if (vc && vidChg < 0)  vidChg = cyc;
      if (fc && freqChg < 0) freqChg = cyc;
      if (vc && fc) dual = 1;
      if ((vc || fc) && !busy) idleChg = 1;
      if (busy) sawBusy = 1;
      freqMask[freqSel] = 1'b1;
      idleRun = busy ? 0 : idleRun + 1;
      pv = vidCode; pf = freqSel;
      cyc++;
      if (idleRun < 2) @(negedge clk);
    end
  endtask

  task automatic moveTo(int idx);
    issue(1'b1, idx, 1'b0, 0);
    track();
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=completion cycles", WDOG);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(vidCode == 6'd32, "R1", "boot vid", vidCode, 32);
    check(freqSel == 0, "R1", "boot freq", freqSel, 0);
    check(busy == 1'b0, "R1", "boot busy", busy, 0);

    // same point at boot keeps the boot voltage
    moveTo(0);
    check(vidCode == 6'd32, "R7", "boot same-point vid", vidCode, 32);
    check(!sawBusy, "R7", "boot same-point busy", sawBusy, 0);

    moveTo(1);
    check(vidCode == expVid(1), "R2", "vid at point 1", vidCode, expVid(1));

    // sweep every start/target pair at several settle values
    for (int s = 0; s < 3; s++) begin
      settleCycles = SW'(s * 2);
      for (int from = 0; from < NPTS; from++) begin
        for (int to = 0; to < NPTS; to++) begin
          moveTo(from);
          issue(1'b1, to, 1'b0, 0);
          track();
          check(vidCode == expVid(to), "R2", "final vid", vidCode, expVid(to));
          check(freqSel == to, "R2", "final freq", freqSel, to);
          check(!dual, "R9", "dual step", dual, 0);
          check(!idleChg, "R8", "change while idle", idleChg, 0);
          if (to > from) begin
            check(vidChg >= 0 && freqChg - vidChg == s * 2 + 1, "R3",
                  "vid-to-freq gap", freqChg - vidChg, s * 2 + 1);
            check(sawBusy, "R8", "busy during up move", sawBusy, 1);
          end else if (to < from) begin
            check(freqChg >= 0 && vidChg > freqChg, "R4",
                  "vid after freq", vidChg - freqChg, 1);
            check(sawBusy, "R8", "busy during down move", sawBusy, 1);
          end else begin
            check(!sawBusy && vidChg < 0 && freqChg < 0, "R7",
                  "same-point activity", int'(sawBusy), 0);
          end
        end
      end
    end

    // arbitration
    settleCycles = SW'(1);
    moveTo(0);
    issue(1'b1, 3, 1'b1, 1); track();
    check(freqSel == 1, "R5", "load 3 / thermal 1", freqSel, 1);
    issue(1'b1, 2, 1'b1, 3); track();
    check(freqSel == 2, "R5", "load 2 / thermal 3", freqSel, 2);
    issue(1'b0, 0, 1'b1, 0); track();
    check(freqSel == 0, "R5", "thermal only", freqSel, 0);
    check(vidCode == expVid(0), "R5", "thermal only vid", vidCode, expVid(0));

    // deferral: 0->3 in flight, then 1 queued and replaced by 2
    settleCycles = SW'(6);
    @(negedge clk);
    loadValid = 1'b1; loadIdx = 2'd3;
    @(negedge clk); loadValid = 1'b0;
    @(negedge clk);
    check(busy == 1'b1, "R8", "busy after accept", busy, 1);
    loadValid = 1'b1; loadIdx = 2'd1;
    @(negedge clk); loadIdx = 2'd2;
    @(negedge clk); loadValid = 1'b0;
    pv = vidCode; pf = freqSel;
    track();
    check(freqMask[3], "R6", "in-flight move reached 3", int'(freqMask[3]), 1);
    check(!freqMask[1], "R6", "overwritten request ran", int'(freqMask[1]), 0);
    check(freqSel == 2, "R6", "deferred final freq", freqSel, 2);
    check(vidCode == expVid(2), "R6", "deferred final vid", vidCode, expVid(2));
    check(!dual, "R9", "dual step in deferral", dual, 0);

    report();
  end

endmodule